// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Replay

This block is a first-in first-out store of 9-bit words. Its depth is a parameter and may be any power of two from 256 to 4096. A writer hands it words by pulsing an active-low write strobe, and a reader takes them in the same order by pulsing an active-low read strobe. The two sides are independent: either may pulse at any time, and neither waits for the other.

The block runs on one clock and samples both strobes. A transfer takes place in the clock where a HIGH-to-LOW change of a strobe is seen, so each pulse moves exactly one word, however long the strobe is held low.

Three level flags report the fill state: empty, full and half. A data-out-enable signal marks when the output word should be treated as driven, which is while the read strobe is low. Flow control is the caller's job. While full is high, the block drops write pulses. While empty is high, read pulses do nothing. A replay input moves the read position back to the first storage location so that the stored words can be read out again. The block honours replay only while both strobes are high.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low, and after it is released, `lvl_empty` is 1, `lvl_full` is 0, `lvl_half` is 0, `dout_en` is 0 and `dout` is 0.
- R2: A falling edge of `wr_stb_n`, seen at a rising clock edge while the buffer is not full, stores `din` and raises the fill level by one at that same edge.
- R3: A falling edge of `rd_stb_n`, seen at a rising clock edge while the buffer is not empty, places the oldest unread word on `dout` at that edge. Words leave in the order they were written.
- R4: `dout_en` equals the inverse of `rd_stb_n` as sampled at the previous rising clock edge.
- R5: A write pulse while `lvl_full` is 1 is dropped. Its data is never read back, and the level does not change.
- R6: A read pulse while `lvl_empty` is 1 leaves `dout` and all flags unchanged.
- R7: `lvl_empty` is 1 exactly when the level is 0. `lvl_full` is 1 exactly when the level equals DEPTH. `lvl_half` is 1 whenever the level is DEPTH/2 or more.
- R8: Read and write pulses seen in the same clock, with the buffer neither empty nor full, keep the level unchanged. If the buffer is empty, only the write happens. If it is full, only the read happens.
- R9: `replay_n` low, with both strobes high, sets the read position to storage location 0. The level becomes the write position, or DEPTH when the write position is 0 and the buffer is not empty. Later reads then return the words again, starting from the first word stored.
- R10: `replay_n` has no effect in any clock where either strobe is low.
- R11: A strobe held low for several clocks transfers exactly one word. The level changes only in clocks where a strobe edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low master reset |
| wr_stb_n | input | 1 | Active-low write strobe |
| rd_stb_n | input | 1 | Active-low read strobe |
| replay_n | input | 1 | Active-low rewind of the read position |
| din | input | 9 | Word to store |
| dout | output | 9 | Last word read |
| dout_en | output | 1 | High while the read strobe is sampled low |
| lvl_empty | output | 1 | Buffer holds no words |
| lvl_full | output | 1 | Buffer holds DEPTH words |
| lvl_half | output | 1 | Buffer holds at least DEPTH/2 words |

## Verification
A transfer, a replay and any change to the flags take effect at the first rising clock edge that samples the strobe low, so each of these results is due one edge after the stimulus. `dout_en` rises at that same edge and falls one edge after the strobe returns high. The bench changes inputs on falling clock edges and reads outputs on the next falling edge. This places every sample half a cycle after the single register stage that produces the result. It also reads `dout_en` one more falling edge after the strobe is released, to confirm that it has gone low.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/strobe_sense.sv
// Samples N active-low strobes; flags a HIGH-to-LOW change per strobe.
module strobe_sense #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stb_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] seen_low
);
  for (genvar i = 0; i < N; i++) begin : g_stb
    logic last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= stb_n[i];
    end
    assign fall[i]     = last_q & ~stb_n[i];
    assign seen_low[i] = ~last_q;
  end
endmodule

// File: rtl/fifo9_store.sv
// Plain storage array: one synchronous write port, one combinational read port.
module fifo9_store
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fifo9_ctrl.sv
// Pointers, fill level and flags.
module fifo9_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fall,
  input  logic          rd_fall,
  input  logic          rewind,
  output logic          do_write,
  output logic          do_read,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [AW:0]   level,
  output logic          is_empty,
  output logic          is_full,
  output logic          is_half
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_LVL = (AW+1)'(DEPTH / 2);

  assign is_empty = (level == '0);
  assign is_full  = (level == FULL_LVL);
  assign is_half  = (level >= HALF_LVL);

  assign do_write = wr_fall & ~is_full;
  assign do_read  = rd_fall & ~is_empty;

  logic [AW:0] rewind_level;
  always_comb begin
    if (wr_ptr == '0 && !is_empty) rewind_level = FULL_LVL;
    else                           rewind_level = {1'b0, wr_ptr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (rewind) begin
      rd_ptr <= '0;
      level  <= rewind_level;
    end else begin
      if (do_write) wr_ptr <= wr_ptr + 1'b1;
      if (do_read)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_write, do_read})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb_n,
  input  logic       rd_stb_n,
  input  logic       replay_n,
  input  logic [8:0] din,
  output logic [8:0] dout,
  output logic       dout_en,
  output logic       lvl_empty,
  output logic       lvl_full,
  output logic       lvl_half
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0] falls, lows;
  logic wr_fall, rd_fall, rewind;
  logic do_write, do_read;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0] level;
  word_t rdata, dout_q;

  strobe_sense #(.N(2)) u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_n    ({rd_stb_n, wr_stb_n}),
    .fall     (falls),
    .seen_low (lows)
  );
  assign wr_fall = falls[0];
  assign rd_fall = falls[1];
  assign dout_en = lows[1];

  assign rewind = ~replay_n & wr_stb_n & rd_stb_n;

  fifo9_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fall  (wr_fall),
    .rd_fall  (rd_fall),
    .rewind   (rewind),
    .do_write (do_write),
    .do_read  (do_read),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .level    (level),
    .is_empty (lvl_empty),
    .is_full  (lvl_full),
    .is_half  (lvl_half)
  );

  fifo9_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (do_write),
    .waddr (wr_ptr),
    .wdata (din),
    .raddr (rd_ptr),
    .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (do_read) dout_q <= rdata;
  end
  assign dout = dout_q;
endmodule

// File: rtl/fifo9_props.sv
module fifo9_props #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb_n,
  input logic          rd_stb_n,
  input logic          replay_n,
  input logic          wr_fall,
  input logic          rd_fall,
  input logic [8:0]    dout,
  input logic          dout_en,
  input logic          lvl_empty,
  input logic          lvl_full,
  input logic          lvl_half,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [AW:0]   level
);
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lvl_empty && lvl_full));

  assert_full_has_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_full |-> lvl_half);

  assert_write_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fall && !rd_fall && !lvl_full && replay_n) |=> level == $past(level) + 1'b1);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fall && !rd_fall && lvl_full) |=> (lvl_full && $stable(wr_ptr)));

  assert_empty_read_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !wr_fall && lvl_empty) |=> ($stable(dout) && lvl_empty));

  assert_both_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fall && rd_fall && !lvl_empty && !lvl_full) |=> $stable(level));

  assert_rewind_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!replay_n && wr_stb_n && rd_stb_n) |=> rd_ptr == '0);

  assert_out_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> dout_en == !$past(rd_stb_n));

  assert_level_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fall && !rd_fall && replay_n) |=> $stable(level));
endmodule

bind strobe_fifo fifo9_props #(.DEPTH(DEPTH)) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_stb_n  (wr_stb_n),
  .rd_stb_n  (rd_stb_n),
  .replay_n  (replay_n),
  .wr_fall   (wr_fall),
  .rd_fall   (rd_fall),
  .dout      (dout),
  .dout_en   (dout_en),
  .lvl_empty (lvl_empty),
  .lvl_full  (lvl_full),
  .lvl_half  (lvl_half),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .level     (level)
);

// File: tb/strobe_fifo_test.sv
module strobe_fifo_test;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb_n = 1'b1, rd_stb_n = 1'b1, replay_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic dout_en, lvl_empty, lvl_full, lvl_half;

  int n_checks = 0;
  int n_fail = 0;
  logic [8:0] model_q[$];
  logic [8:0] last_out;

  always #5 clk = ~clk;

  strobe_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb_n(wr_stb_n), .rd_stb_n(rd_stb_n),
    .replay_n(replay_n), .din(din), .dout(dout), .dout_en(dout_en),
    .lvl_empty(lvl_empty), .lvl_full(lvl_full), .lvl_half(lvl_half)
  );

  // {op[1]=read, op[0]=write, data}
  localparam logic [10:0] VEC [0:13] = '{
    {2'b01, 9'h101}, {2'b01, 9'h0A2}, {2'b01, 9'h1F3}, {2'b10, 9'h000},
    {2'b11, 9'h044}, {2'b10, 9'h000}, {2'b10, 9'h000}, {2'b10, 9'h000},
    {2'b11, 9'h155}, {2'b10, 9'h000}, {2'b01, 9'h066}, {2'b11, 9'h1A7},
    {2'b10, 9'h000}, {2'b10, 9'h000}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk(req, lvl_empty, model_q.size() == 0);
    chk(req, lvl_full,  model_q.size() == DEPTH);
    chk(req, lvl_half,  model_q.size() >= DEPTH / 2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_stb_n = 1'b1; rd_stb_n = 1'b1; replay_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    model_q.delete();
    last_out = '0;
  endtask

  // One strobe pulse: low for one clock, then high; dout sampled before release.
  task automatic pulse(input bit w, input bit r, input logic [8:0] d, input string req);
    bit can_w, can_r;
    logic [8:0] exp_out;
    can_r = r && model_q.size() > 0;
    can_w = w && model_q.size() < DEPTH;
    exp_out = last_out;
    if (can_r) exp_out = model_q.pop_front();
    if (can_w) model_q.push_back(d);
    @(negedge clk);
    din = d; wr_stb_n = !w; rd_stb_n = !r;
    @(negedge clk);
    if (r) begin
      chk({req, " data"}, dout, exp_out);
      chk("R4 enable high", dout_en, 1);
    end
    last_out = exp_out;
    chk_flags({req, " flags"});
    wr_stb_n = 1'b1; rd_stb_n = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 empty", lvl_empty, 1);
    chk("R1 full", lvl_full, 0);
    chk("R1 half", lvl_half, 0);
    chk("R1 dout_en", dout_en, 0);
    chk("R1 dout", dout, 0);
    do_reset();
    chk("R1 after release", {lvl_empty, lvl_full, lvl_half, dout_en}, 4'b1000);

    // Vector walk: R2, R3, R6, R8
    foreach (VEC[i]) begin
      pulse(VEC[i][9], VEC[i][10], VEC[i][8:0], "R3/R8 vector");
    end

    // R4: enable drops one edge after release
    pulse(1, 0, 9'h011, "R2 write");
    pulse(0, 1, 9'h000, "R3 read");
    @(negedge clk);
    chk("R4 enable low", dout_en, 0);

    // R7 boundaries, R5 overflow, R8 on full
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      pulse(1, 0, 9'((i * 7) ^ 9'h0C3), "R7 fill");
    end
    pulse(1, 0, 9'h1FF, "R5 write when full");
    pulse(1, 1, 9'h1EE, "R8 both on full");
    for (int i = 1; i < DEPTH; i++) begin
      pulse(0, 1, 9'h000, "R5 drain");
    end
    pulse(0, 1, 9'h000, "R6 read when empty");

    // R11 held strobe
    do_reset();
    @(negedge clk);
    din = 9'h0B4; wr_stb_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_stb_n = 1'b1;
    model_q.push_back(9'h0B4);
    pulse(0, 1, 9'h000, "R11 one word");
    chk("R11 empty after", lvl_empty, 1);

    // R9 replay
    do_reset();
    for (int i = 0; i < 5; i++) pulse(1, 0, 9'(9'h120 + i), "R9 load");
    pulse(0, 1, 9'h000, "R9 read");
    pulse(0, 1, 9'h000, "R9 read");
    @(negedge clk);
    replay_n = 1'b0;
    @(negedge clk);
    replay_n = 1'b1;
    model_q.delete();
    for (int i = 0; i < 5; i++) model_q.push_back(9'(9'h120 + i));
    chk("R9 not empty", lvl_empty, 0);
    for (int i = 0; i < 5; i++) pulse(0, 1, 9'h000, "R9 replay");
    chk("R9 empty at end", lvl_empty, 1);

    // R10 replay ignored while read strobe low
    do_reset();
    for (int i = 0; i < 5; i++) pulse(1, 0, 9'(9'h040 + i), "R10 load");
    pulse(0, 1, 9'h000, "R10 read");
    @(negedge clk);
    rd_stb_n = 1'b0; replay_n = 1'b0;
    @(negedge clk);
    chk("R10 read during replay", dout, 9'h041);
    @(negedge clk);
    rd_stb_n = 1'b1; replay_n = 1'b1;
    void'(model_q.pop_front());
    last_out = 9'h041;
    pulse(0, 1, 9'h000, "R10 no rewind");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule